// File: doc/BRIEF.md
# USB Host Wrapper Control and Interrupt Register Bank

This block is a small memory-mapped register bank that sits beside a USB host controller. Software reaches it over a simple single-cycle 32-bit register bus: a select strobe, write enable, word address and write data going in, and registered read data plus an error flag coming back. The bank holds static configuration that drives the controller directly: a bus-filter bypass nibble, five port option bits, a frame-length adjust value, an endianness select, a coherency select and a bus-master enable. It also holds one spare 32-bit scratch word.

A two-source error interrupt group sits next to the configuration. Source 0 is an address-decode error and source 1 is a host system error. Hardware pulses set the status bits, and software clears them by writing ones. The mask cannot be written directly. One register clears mask bits where ones are written, and another sets them. A single level interrupt output is high while any unmasked status bit is set. When the error-response enable bit is on, an access to an undefined offset fails on the bus and also records an address-decode error.

Top module: `usbw_csr`

## Requirements
- R1: After reset, frame adjust (0x38) reads 0x20, bus-master enable (0x48) reads 1, the mask (0x68) reads 0x3, and every other register and configuration output is 0. The interrupt output is low.
- R2: The configuration registers are read/write at these offsets, with reserved upper bits reading 0: bypass at 0x30 (bits 3:0), port options at 0x34 (bits 4:0), frame adjust at 0x38 (bits 5:0), endianness at 0x40, coherency at 0x44, bus-master enable at 0x48 (bit 0 each), error-response enable at 0x60 (bit 0), and a full 32-bit spare at 0x78. Each stored field also appears on its output pin.
- R3: At status offset 0x64, bit 0 is the address-decode error and bit 1 is the host system error. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R4: A write to the mask offset 0x68 has no effect.
- R5: A write to offset 0x6C clears every mask bit where the data is 1. A write to offset 0x70 sets every mask bit where the data is 1. Both offsets read as 0.
- R6: The interrupt output is high exactly when some status bit is 1 and its mask bit is 0.
- R7: A pulse on an event input sets the matching status bit. If the pulse and a write-1-to-clear of that bit fall in the same cycle, the bit ends up set.
- R8: An access to any other offset, including a misaligned one, returns read data 0. It raises the error flag and sets status bit 0 only when bit 0 of 0x60 is 1. Otherwise no error is reported and nothing changes.
- R9: Read data and the error flag are valid in the cycle after the access. In all other cycles they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Error response, one cycle after the access |
| ev_addr_err | input | 1 | Pulse that sets status bit 0 |
| ev_host_err | input | 1 | Pulse that sets status bit 1 |
| filt_bypass | output | 4 | Bus filter bypass |
| port_ctl | output | 5 | Port option bits |
| frame_adj | output | 6 | Frame-length adjust |
| big_endian | output | 1 | Endianness select |
| coherent | output | 1 | Coherency select |
| bus_master_en | output | 1 | Bus-master enable |
| irq | output | 1 | Level interrupt |

## Verification
Every result lands one clock edge after the stimulus that causes it. A write updates the configuration pins, status, mask and interrupt level at the edge that captures it. A read's data and error flag are registered at that same edge. The driver launches each access at a falling edge and holds it for one cycle. It queues the expected response, and the monitor pops and compares the queue at the next falling edge, by which time the response has been registered. Output pins are sampled at that same falling edge, half a period after the edge that updated them, so no comparison races the clock.

// File: rtl/usbw_csr_pkg.sv
package usbw_csr_pkg;
  localparam int DW     = 32;
  localparam int FILT_W = 4;
  localparam int PORT_W = 5;
  localparam int FADJ_W = 6;
  localparam int NSRC   = 2;

  localparam logic [7:0] OFS_FILT = 8'h30;
  localparam logic [7:0] OFS_PORT = 8'h34;
  localparam logic [7:0] OFS_FADJ = 8'h38;
  localparam logic [7:0] OFS_ENDN = 8'h40;
  localparam logic [7:0] OFS_COH  = 8'h44;
  localparam logic [7:0] OFS_BME  = 8'h48;
  localparam logic [7:0] OFS_CTL  = 8'h60;
  localparam logic [7:0] OFS_STAT = 8'h64;
  localparam logic [7:0] OFS_MASK = 8'h68;
  localparam logic [7:0] OFS_IEN  = 8'h6C;
  localparam logic [7:0] OFS_IDIS = 8'h70;
  localparam logic [7:0] OFS_SPR  = 8'h78;

  localparam logic [FADJ_W-1:0] FADJ_RST = 6'h20;
  localparam logic [NSRC-1:0]   MASK_RST = '1;

  typedef enum logic [3:0] {
    RID_FILT, RID_PORT, RID_FADJ, RID_ENDN, RID_COH, RID_BME,
    RID_CTL, RID_STAT, RID_MASK, RID_IEN, RID_IDIS, RID_SPR, RID_NONE
  } rid_e;
endpackage

// File: rtl/usbw_csr_dec.sv
module usbw_csr_dec
  import usbw_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output rid_e              rid,
  output logic              hit
);
  always_comb begin
    case (addr)
      ADDR_W'(OFS_FILT): rid = RID_FILT;
      ADDR_W'(OFS_PORT): rid = RID_PORT;
      ADDR_W'(OFS_FADJ): rid = RID_FADJ;
      ADDR_W'(OFS_ENDN): rid = RID_ENDN;
      ADDR_W'(OFS_COH):  rid = RID_COH;
      ADDR_W'(OFS_BME):  rid = RID_BME;
      ADDR_W'(OFS_CTL):  rid = RID_CTL;
      ADDR_W'(OFS_STAT): rid = RID_STAT;
      ADDR_W'(OFS_MASK): rid = RID_MASK;
      ADDR_W'(OFS_IEN):  rid = RID_IEN;
      ADDR_W'(OFS_IDIS): rid = RID_IDIS;
      ADDR_W'(OFS_SPR):  rid = RID_SPR;
      default:           rid = RID_NONE;
    endcase
  end

  assign hit = (rid != RID_NONE);
endmodule

// File: rtl/usbw_csr_cfg.sv
module usbw_csr_cfg
  import usbw_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  rid_e              rid,
  input  logic [DW-1:0]     wdata,
  output logic [FILT_W-1:0] filt_q,
  output logic [PORT_W-1:0] port_q,
  output logic [FADJ_W-1:0] fadj_q,
  output logic              endn_q,
  output logic              coh_q,
  output logic              bme_q,
  output logic              ctl_q,
  output logic [DW-1:0]     spr_q
);
  logic [FILT_W-1:0] filt_d;
  logic [PORT_W-1:0] port_d;
  logic [FADJ_W-1:0] fadj_d;
  logic              endn_d, coh_d, bme_d, ctl_d;
  logic [DW-1:0]     spr_d;

  always_comb begin
    filt_d = filt_q;
    port_d = port_q;
    fadj_d = fadj_q;
    endn_d = endn_q;
    coh_d  = coh_q;
    bme_d  = bme_q;
    ctl_d  = ctl_q;
    spr_d  = spr_q;
    if (wr_en) begin
      case (rid)
        RID_FILT: filt_d = wdata[FILT_W-1:0];
        RID_PORT: port_d = wdata[PORT_W-1:0];
        RID_FADJ: fadj_d = wdata[FADJ_W-1:0];
        RID_ENDN: endn_d = wdata[0];
        RID_COH:  coh_d  = wdata[0];
        RID_BME:  bme_d  = wdata[0];
        RID_CTL:  ctl_d  = wdata[0];
        RID_SPR:  spr_d  = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      port_q <= '0;
      fadj_q <= FADJ_RST;
      endn_q <= 1'b0;
      coh_q  <= 1'b0;
      bme_q  <= 1'b1;
      ctl_q  <= 1'b0;
      spr_q  <= '0;
    end else begin
      filt_q <= filt_d;
      port_q <= port_d;
      fadj_q <= fadj_d;
      endn_q <= endn_d;
      coh_q  <= coh_d;
      bme_q  <= bme_d;
      ctl_q  <= ctl_d;
      spr_q  <= spr_d;
    end
  end

  AST_FADJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rid == RID_FADJ) |=> $stable(fadj_q)) else $error("fadj changed"); // R2
endmodule

// File: rtl/usbw_csr_irq.sv
module usbw_csr_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_set,
  input  logic            wr_stat,
  input  logic            wr_ien,
  input  logic            wr_idis,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] stat_q,
  output logic [NSRC-1:0] mask_q,
  output logic            irq
);
  logic [NSRC-1:0] stat_d, mask_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      stat_d[i] = ev_set[i] | (stat_q[i] & ~(wr_stat & wdata[i]));
      if (wr_ien)       mask_d[i] = mask_q[i] & ~wdata[i];
      else if (wr_idis) mask_d[i] = mask_q[i] | wdata[i];
      else              mask_d[i] = mask_q[i];
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[i] && !ev_set[i]) |=> !stat_q[i]) else $error("w1c"); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_set[i] |=> stat_q[i]) else $error("set lost"); // R7
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |(stat_q & ~mask_q);

  AST_MASK_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_q) |-> $past(wr_ien || wr_idis)) else $error("mask moved"); // R4
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> ((mask_q & $past(wdata)) == '0)) else $error("enable"); // R5
  AST_DIS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idis |=> ((mask_q & $past(wdata)) == $past(wdata))) else $error("disable"); // R5
endmodule

// File: rtl/usbw_csr.sv
module usbw_csr
  import usbw_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  input  logic              ev_addr_err,
  input  logic              ev_host_err,
  output logic [FILT_W-1:0] filt_bypass,
  output logic [PORT_W-1:0] port_ctl,
  output logic [FADJ_W-1:0] frame_adj,
  output logic              big_endian,
  output logic              coherent,
  output logic              bus_master_en,
  output logic              irq
);
  logic rst_s1, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  rid_e rid;
  logic hit;
  usbw_csr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .rid(rid), .hit(hit));

  logic wr_any;
  assign wr_any = bus_sel && bus_we && rst_sync;

  logic ctl_q;
  logic [DW-1:0] spr_q;
  usbw_csr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_any), .rid(rid), .wdata(bus_wdata),
    .filt_q(filt_bypass), .port_q(port_ctl), .fadj_q(frame_adj),
    .endn_q(big_endian), .coh_q(coherent), .bme_q(bus_master_en),
    .ctl_q(ctl_q), .spr_q(spr_q)
  );

  logic undef_err;
  assign undef_err = bus_sel && rst_sync && !hit && ctl_q;

  logic [NSRC-1:0] ev_set, stat_q, mask_q;
  assign ev_set = {ev_host_err, ev_addr_err | undef_err};

  usbw_csr_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set),
    .wr_stat(wr_any && rid == RID_STAT),
    .wr_ien(wr_any && rid == RID_IEN),
    .wr_idis(wr_any && rid == RID_IDIS),
    .wdata(bus_wdata[NSRC-1:0]),
    .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
  );

  logic [DW-1:0] rd_mux, rdata_d;
  logic          err_d;
  always_comb begin
    case (rid)
      RID_FILT: rd_mux = DW'(filt_bypass);
      RID_PORT: rd_mux = DW'(port_ctl);
      RID_FADJ: rd_mux = DW'(frame_adj);
      RID_ENDN: rd_mux = DW'(big_endian);
      RID_COH:  rd_mux = DW'(coherent);
      RID_BME:  rd_mux = DW'(bus_master_en);
      RID_CTL:  rd_mux = DW'(ctl_q);
      RID_STAT: rd_mux = DW'(stat_q);
      RID_MASK: rd_mux = DW'(mask_q);
      RID_SPR:  rd_mux = spr_q;
      default:  rd_mux = '0;
    endcase
    rdata_d = (bus_sel && !bus_we && rst_sync) ? rd_mux : '0;
    err_d   = undef_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= err_d;
    end
  end

  AST_ERR_UNDEF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel && !hit)) else $error("err"); // R8
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (rid == RID_IEN || rid == RID_IDIS)) |=> (bus_rdata == '0))
    else $error("wo read"); // R5
  AST_IRQ_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && rid == RID_IEN && (bus_wdata[NSRC-1:0] & stat_q) != '0) |=> irq)
    else $error("irq"); // R6
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel) |-> (bus_rdata == '0 && !bus_err)) else $error("idle rsp"); // R9
endmodule

// File: tb/sim_usbw_csr.sv
module sim_usbw_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        ev_addr_err = 1'b0, ev_host_err = 1'b0;
  logic [3:0]  filt_bypass;
  logic [4:0]  port_ctl;
  logic [5:0]  frame_adj;
  logic        big_endian, coherent, bus_master_en, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [31:0] rd; logic err; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  usbw_csr u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [31:0] erd, input logic eerr, input string tag,
                     input logic [1:0] ev = 2'b00);
    exp_t e;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    {ev_host_err, ev_addr_err} = ev;
    e.rd = erd; e.err = eerr; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; {ev_host_err, ev_addr_err} = 2'b00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    acc(1'b1, a, d, 32'h0, 1'b0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    acc(1'b0, a, 32'h0, exp, 1'b0, tag);
  endtask

  task automatic pulse(input logic [1:0] ev);
    @(negedge clk);
    {ev_host_err, ev_addr_err} = ev;
    @(negedge clk);
    {ev_host_err, ev_addr_err} = 2'b00;
  endtask

  // monitor: response is registered at the edge after the access
  initial begin
    forever begin
      bit was;
      @(posedge clk);
      was = bus_sel;
      @(negedge clk);
      if (was) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " rdata"}, bus_rdata, e.rd);
        chk({e.tag, " err"}, {31'b0, bus_err}, {31'b0, e.err});
      end else begin
        chk("R9 idle rsp", bus_rdata | {31'b0, bus_err}, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 frame_adj", 32'(frame_adj), 32'h20);
    chk("R1 bme", 32'(bus_master_en), 32'h1);
    chk("R1 others", {filt_bypass, port_ctl, big_endian, coherent}, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(8'h38, 32'h20, "R1 fadj rd");
    rd(8'h48, 32'h1, "R1 bme rd");
    rd(8'h68, 32'h3, "R1 mask rd");
    rd(8'h64, 32'h0, "R1 stat rd");
    rd(8'h60, 32'h0, "R1 ctl rd");
    rd(8'h78, 32'h0, "R1 spare rd");
    // R2 config fields
    wr(8'h30, 32'hFFFF_FFFF, "R2 wr filt");
    rd(8'h30, 32'hF, "R2 filt rd");
    chk("R2 filt pin", 32'(filt_bypass), 32'hF);
    wr(8'h34, 32'hFFFF_FFEA, "R2 wr port");
    rd(8'h34, 32'h0A, "R2 port rd");
    chk("R2 port pin", 32'(port_ctl), 32'h0A);
    wr(8'h38, 32'hFFFF_FF07, "R2 wr fadj");
    rd(8'h38, 32'h07, "R2 fadj rd");
    chk("R2 fadj pin", 32'(frame_adj), 32'h07);
    wr(8'h40, 32'h1, "R2 wr endn");
    wr(8'h44, 32'hFFFF_FFFF, "R2 wr coh");
    wr(8'h48, 32'h0, "R2 wr bme");
    rd(8'h44, 32'h1, "R2 coh rd");
    chk("R2 pins", {29'b0, big_endian, coherent, bus_master_en}, 32'h6);
    wr(8'h78, 32'hA5A5_1234, "R2 wr spare");
    rd(8'h78, 32'hA5A5_1234, "R2 spare rd");
    // R4 mask read-only
    wr(8'h68, 32'h0, "R4 wr mask");
    rd(8'h68, 32'h3, "R4 mask rd");
    // R7 event sets status; R6 masked -> no irq
    pulse(2'b10);
    rd(8'h64, 32'h2, "R7 stat rd");
    chk("R6 masked irq", 32'(irq), 32'h0);
    // R5 enable
    wr(8'h6C, 32'h2, "R5 wr ien");
    rd(8'h68, 32'h1, "R5 mask after ien");
    chk("R6 irq on", 32'(irq), 32'h1);
    rd(8'h6C, 32'h0, "R5 ien rd");
    rd(8'h70, 32'h0, "R5 idis rd");
    // R3 w1c
    wr(8'h64, 32'h1, "R3 wr other bit");
    rd(8'h64, 32'h2, "R3 stat kept");
    wr(8'h64, 32'h2, "R3 wr clear");
    chk("R6 irq off", 32'(irq), 32'h0);
    rd(8'h64, 32'h0, "R3 stat cleared");
    // R7 set beats clear
    acc(1'b1, 8'h64, 32'h2, 32'h0, 1'b0, "R7 set+clr", 2'b10);
    rd(8'h64, 32'h2, "R7 set wins");
    chk("R7 irq", 32'(irq), 32'h1);
    // R5 disable
    wr(8'h70, 32'h2, "R5 wr idis");
    chk("R5 irq masked", 32'(irq), 32'h0);
    rd(8'h68, 32'h3, "R5 mask after idis");
    wr(8'h64, 32'h3, "R3 clr all");
    // R8 undefined access, error response off
    rd(8'h50, 32'h0, "R8 undef noerr");
    rd(8'h64, 32'h0, "R8 stat untouched");
    wr(8'h60, 32'h1, "R8 wr ctl");
    rd(8'h60, 32'h1, "R8 ctl rd");
    acc(1'b0, 8'h50, 32'h0, 32'h0, 1'b1, "R8 undef err");
    rd(8'h64, 32'h1, "R8 stat set");
    acc(1'b0, 8'h31, 32'h0, 32'h0, 1'b1, "R8 misaligned");
    acc(1'b1, 8'h7C, 32'hFFFF_FFFF, 32'h0, 1'b1, "R8 undef wr");
    wr(8'h6C, 32'h1, "R6 unmask src0");
    chk("R6 irq src0", 32'(irq), 32'h1);
    wr(8'h64, 32'h1, "R3 clr src0");
    chk("R6 irq cleared", 32'(irq), 32'h0);
    pulse(2'b01);
    chk("R7 addr ev irq", 32'(irq), 32'h1);
    rd(8'h64, 32'h1, "R7 addr ev stat");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule